// File: doc/BRIEF.md
# PHY Management Bring-up and Status Poller

This block is the management master for a bank of external Ethernet PHYs sitting on one shared two-wire management bus. It leaves reset and initialises each PHY in turn. First it writes the PHY's ability advertisement, including symmetric pause when flow control was enabled at reset. Then it writes the control register to restart auto-negotiation. Once every PHY has been initialised, the block never stops cycling through the PHYs. For each one it reads the basic status register and the link-partner ability register, and it keeps a per-port table of link, speed, duplex and pause results.

The PHYs occupy a contiguous block of addresses that starts at a base address. A strap input chooses how ports map onto those addresses: port p uses base+p, or the order is reversed so that port p uses base+N-1-p. A second strap enables flow control. Both straps are captured only while reset is asserted. The management clock is derived from the system clock. The data line is presented as an output value with an output enable, so the pad can tri-state it.

Top module: `mdio_phy_manager`

## Requirements
- R1: The management clock is low throughout reset. After reset it is low for MDC_HALF system clocks and then high for MDC_HALF, repeating, so that after k clock edges out of reset it equals ((k mod 2*MDC_HALF) >= MDC_HALF).
- R2: Every frame begins with exactly 32 driven ones, followed by the start pair 0 then 1. Next come a 2-bit opcode (01 write, 10 read), a 5-bit PHY address and a 5-bit register number, all MSB first.
- R3: In a write frame the master drives the turnaround as 1 then 0, followed by 16 data bits MSB first. It then releases the line (enable low) for at least the next clock period.
- R4: In a read frame the enable is low from the first turnaround bit through the last data bit. The 16 data bits are captured MSB first at the rising edges of the management clock.
- R5: The data output and its enable change only at the system clock edge where the management clock falls.
- R6: After reset, the addresses base..base+N-1 are visited in ascending order. Each address receives a write to register 4 and then a write to register 0 with value 0x1200, which restarts auto-negotiation.
- R7: The register 4 value is 0x01E1, with bit 10 also set (0x05E1) when the flow-control strap was high during reset.
- R8: Strap changes after reset is released have no effect until the next reset.
- R9: Once initialisation is complete, init_done stays high. From then on, addresses are visited in ascending order without end, each with a read of register 1 and then a read of register 5, and no further writes are issued.
- R10: Table entry p belongs to address base+p when the reverse strap was low during reset, and to address base+N-1-p when it was high.
- R11: After the register 5 read of an address completes, that address's port entry is updated. Link is taken from register 1 bit 2. With link up: speed_100 = bit8|bit7, full_duplex = bit8 | (!bit7 & bit6), and pause_en = bit10 AND the flow-control strap. With link down, all three are 0.
- R12: While reset is held, mdc, mdio_oe, init_done and every table output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| flowctl_strap | input | 1 | Flow-control enable strap |
| reverse_strap | input | 1 | Port-to-address reversal strap |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data value to drive |
| mdio_oe | output | 1 | Drive enable for the management data line |
| init_done | output | 1 | High once every PHY has been initialised |
| link_up | output | NUM_PORTS | Per-port link state |
| speed_100 | output | NUM_PORTS | Per-port resolved 100 Mb/s |
| full_duplex | output | NUM_PORTS | Per-port resolved full duplex |
| pause_en | output | NUM_PORTS | Per-port pause enabled |

## Verification
The hardest condition to reach from the ports is a table in which every port shows a different ability resolution, including a link-down port whose partner still advertises pause, and in which those results stay attached to the right port under both address orderings. The bench's PHY model returns register contents chosen by address and by poll round, so successive rounds move every resolution case across the ports. A second reset with both straps inverted then repeats the sequence with the reversed mapping and pause disabled, and both straps are toggled after each reset release to show that they are ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef enum logic [1:0] {
        STEP_ADV,
        STEP_RESTART,
        STEP_LINK,
        STEP_PARTNER
    } step_e;

    typedef struct packed {
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  reg_addr;
        logic [15:0] wdata;
    } mdio_req_t;

    typedef struct packed {
        logic link;
        logic spd100;
        logic full;
        logic pause;
    } port_stat_t;

    localparam logic [4:0]  REG_CTRL     = 5'd0;
    localparam logic [4:0]  REG_STATUS   = 5'd1;
    localparam logic [4:0]  REG_ADV      = 5'd4;
    localparam logic [4:0]  REG_PARTNER  = 5'd5;
    localparam logic [15:0] ADV_BASE     = 16'h01E1;
    localparam logic [15:0] ADV_PAUSE    = 16'h0400;
    localparam logic [15:0] CTRL_RESTART = 16'h1200;

    // Serial image of one frame, MSB leaves first.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
        logic [1:0]  ta;
        logic [15:0] body;
        ta   = (r.op == OP_WRITE) ? 2'b10 : 2'b11;
        body = (r.op == OP_WRITE) ? r.wdata : 16'hFFFF;
        return {{PRE_BITS{1'b1}}, 2'b01, r.op, r.phy, r.reg_addr, ta, body};
    endfunction

    // Highest common mode: 100 full, 100 half, 10 full, 10 half.
    function automatic port_stat_t decode_stat(input logic link, input logic [15:0] partner,
                                               input logic fc);
        port_stat_t s;
        s = '0;
        if (link) begin
            s.link   = 1'b1;
            s.spd100 = partner[8] | partner[7];
            s.full   = partner[8] | (~partner[7] & partner[6]);
            s.pause  = partner[10] & fc;
        end
        return s;
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int HALF = 16
) (
    input  logic clk,
    input  logic rst,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PERIOD = 2 * HALF;
    localparam int CW     = $clog2(PERIOD);
    localparam logic [CW-1:0] CNT_RISE = CW'(HALF - 1);
    localparam logic [CW-1:0] CNT_FALL = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign rise_o = (cnt_q == CNT_RISE);
    assign fall_o = (cnt_q == CNT_FALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else begin
            cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
            if (rise_o)      mdc_o <= 1'b1;
            else if (fall_o) mdc_o <= 1'b0;
        end
    end

    p_rise_strobe_r1: assert property (@(posedge clk) disable iff (rst) rise_o |=> mdc_o);
    p_fall_strobe_r1: assert property (@(posedge clk) disable iff (rst) fall_o |=> !mdc_o);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        start_i,
    input  mdio_req_t   req_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_TAIL} eng_state_e;
    localparam int PW = $clog2(FRAME_BITS + 1);
    localparam logic [PW-1:0] POS_END  = PW'(FRAME_BITS);
    localparam logic [PW-1:0] POS_TA   = PW'(TA_POS);
    localparam logic [PW-1:0] POS_DATA = PW'(DATA_POS);

    eng_state_e            state_q;
    logic [FRAME_BITS-1:0] shift_q;
    logic [PW-1:0]         pos_q;
    logic                  rd_q;

    assign busy_o = (state_q != E_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= E_IDLE;
            shift_q   <= '0;
            pos_q     <= '0;
            rd_q      <= 1'b0;
            done_o    <= 1'b0;
            rdata_o   <= '0;
            mdio_o    <= 1'b0;
            mdio_oe_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                E_IDLE: begin
                    if (start_i) begin
                        shift_q <= build_frame(req_i);
                        pos_q   <= '0;
                        rd_q    <= (req_i.op == OP_READ);
                        state_q <= E_SHIFT;
                    end
                end
                E_SHIFT: begin
                    if (fall_i) begin
                        if (pos_q == POS_END) begin
                            mdio_oe_o <= 1'b0;
                            state_q   <= E_TAIL;
                        end else begin
                            mdio_o    <= shift_q[FRAME_BITS-1];
                            shift_q   <= {shift_q[FRAME_BITS-2:0], 1'b0};
                            mdio_oe_o <= !(rd_q && pos_q >= POS_TA);
                            pos_q     <= pos_q + 1'b1;
                        end
                    end
                    // bit k is on the line while pos_q == k+1
                    if (rise_i && rd_q && pos_q > POS_DATA)
                        rdata_o <= {rdata_o[14:0], mdio_i};
                end
                E_TAIL: begin
                    if (fall_i) begin
                        done_o  <= 1'b1;
                        state_q <= E_IDLE;
                    end
                end
                default: state_q <= E_IDLE;
            endcase
        end
    end

    p_data_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $past(fall_i));
    p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe_o) |-> $past(fall_i));
    p_read_release_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == E_SHIFT && rd_q && pos_q > POS_TA) |-> !mdio_oe_o);

endmodule

// File: rtl/mdio_poll_sequencer.sv
module mdio_poll_sequencer
    import mdio_pkg::*;
#(
    parameter int         NUM_PORTS = 8,
    parameter logic [4:0] BASE_ADDR = 5'b01000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fc_en_i,
    input  logic                         rev_i,
    input  logic                         busy_i,
    input  logic                         done_i,
    input  logic [15:0]                  rdata_i,
    output logic                         start_o,
    output mdio_req_t                    req_o,
    output logic                         init_done_o,
    output port_stat_t [NUM_PORTS-1:0]   table_o
);
    localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [IW-1:0] LAST = IW'(NUM_PORTS - 1);

    step_e         step_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] port_idx;
    logic          issued_q;
    logic          link_q;

    assign port_idx = rev_i ? (LAST - idx_q) : idx_q;

    always_comb begin
        req_o          = '0;
        req_o.phy      = BASE_ADDR + 5'(idx_q);
        req_o.op       = OP_READ;
        req_o.reg_addr = REG_STATUS;
        unique case (step_q)
            STEP_ADV: begin
                req_o.op       = OP_WRITE;
                req_o.reg_addr = REG_ADV;
                req_o.wdata    = ADV_BASE | (fc_en_i ? ADV_PAUSE : 16'h0000);
            end
            STEP_RESTART: begin
                req_o.op       = OP_WRITE;
                req_o.reg_addr = REG_CTRL;
                req_o.wdata    = CTRL_RESTART;
            end
            STEP_PARTNER: req_o.reg_addr = REG_PARTNER;
            default:      req_o.reg_addr = REG_STATUS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q      <= STEP_ADV;
            idx_q       <= '0;
            issued_q    <= 1'b0;
            link_q      <= 1'b0;
            start_o     <= 1'b0;
            init_done_o <= 1'b0;
            table_o     <= '0;
        end else begin
            start_o <= 1'b0;
            if (!issued_q && !busy_i && !start_o) begin
                start_o  <= 1'b1;
                issued_q <= 1'b1;
            end
            if (done_i) begin
                issued_q <= 1'b0;
                unique case (step_q)
                    STEP_ADV: step_q <= STEP_RESTART;
                    STEP_RESTART: begin
                        if (idx_q == LAST) begin
                            idx_q       <= '0;
                            step_q      <= STEP_LINK;
                            init_done_o <= 1'b1;
                        end else begin
                            idx_q  <= idx_q + 1'b1;
                            step_q <= STEP_ADV;
                        end
                    end
                    STEP_LINK: begin
                        link_q <= rdata_i[2];
                        step_q <= STEP_PARTNER;
                    end
                    default: begin
                        table_o[port_idx] <= decode_stat(link_q, rdata_i, fc_en_i);
                        step_q <= STEP_LINK;
                        idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                    end
                endcase
            end
        end
    end

    p_done_after_issue_r9: assert property (@(posedge clk) disable iff (rst)
        done_i |-> issued_q);
    p_init_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);
    p_poll_reads_only_r9: assert property (@(posedge clk) disable iff (rst)
        (init_done_o && start_o) |-> (req_o.op == OP_READ));

endmodule

// File: rtl/mdio_phy_manager.sv
module mdio_phy_manager
    import mdio_pkg::*;
#(
    parameter int         NUM_PORTS = 8,
    parameter int         MDC_HALF  = 16,
    parameter logic [4:0] BASE_ADDR = 5'b01000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flowctl_strap,
    input  logic                 reverse_strap,
    input  logic                 mdio_i,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 init_done,
    output logic [NUM_PORTS-1:0] link_up,
    output logic [NUM_PORTS-1:0] speed_100,
    output logic [NUM_PORTS-1:0] full_duplex,
    output logic [NUM_PORTS-1:0] pause_en
);
    logic                        fc_q;
    logic                        rev_q;
    logic                        rise;
    logic                        fall;
    logic                        start;
    logic                        busy;
    logic                        done;
    logic [15:0]                 rdata;
    mdio_req_t                   req;
    port_stat_t [NUM_PORTS-1:0]  tbl;

    // straps follow the pins only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q  <= flowctl_strap;
            rev_q <= reverse_strap;
        end
    end

    mdio_clk_gen #(.HALF(MDC_HALF)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .fall_i    (fall),
        .start_i   (start),
        .req_i     (req),
        .mdio_i    (mdio_i),
        .busy_o    (busy),
        .done_o    (done),
        .rdata_o   (rdata),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    mdio_poll_sequencer #(.NUM_PORTS(NUM_PORTS), .BASE_ADDR(BASE_ADDR)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .fc_en_i     (fc_q),
        .rev_i       (rev_q),
        .busy_i      (busy),
        .done_i      (done),
        .rdata_i     (rdata),
        .start_o     (start),
        .req_o       (req),
        .init_done_o (init_done),
        .table_o     (tbl)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign link_up[p]     = tbl[p].link;
        assign speed_100[p]   = tbl[p].spd100;
        assign full_duplex[p] = tbl[p].full;
        assign pause_en[p]    = tbl[p].pause;

        p_down_clear_r11: assert property (@(posedge clk) disable iff (rst)
            !link_up[p] |-> !(speed_100[p] || full_duplex[p] || pause_en[p]));
        p_pause_needs_fc_r7: assert property (@(posedge clk) disable iff (rst)
            pause_en[p] |-> fc_q);
    end

endmodule

// File: tb/test_mdio_phy_manager.sv
module test_mdio_phy_manager;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 6;
    localparam int BASE       = 8;
    localparam int WATCHDOG   = 195000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fc_pin = 1'b0;
    logic rev_pin = 1'b0;
    logic phy_drv = 1'b0;
    logic phy_val = 1'b0;
    logic mdio_line;
    logic mdc, mdio_o, mdio_oe, init_done;
    logic [NP-1:0] link_up, speed_100, full_duplex, pause_en;

    int n_cmp = 0;
    int n_bad = 0;
    int k = 0;
    int ones = 0;
    int pos = -1;
    int fidx = 0;
    int pend_port = 0;
    bit pend = 0;
    bit fc_s = 0;
    bit rev_s = 0;
    bit ended = 0;
    logic [3:0]  pend_exp;
    logic [12:0] hdr;
    logic [15:0] dat;
    logic [15:0] rd_val;
    logic        is_rd = 1'b0;
    logic        after_frame = 1'b0;
    logic        prev_mdc = 1'b0;
    logic        rst_d = 1'b0;
    logic [1:0]  prev_line = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_phy_manager #(.NUM_PORTS(NP)) i_mdio_phy_manager (
        .clk           (clk),
        .rst           (rst),
        .flowctl_strap (fc_pin),
        .reverse_strap (rev_pin),
        .mdio_i        (mdio_line),
        .mdc           (mdc),
        .mdio_o        (mdio_o),
        .mdio_oe       (mdio_oe),
        .init_done     (init_done),
        .link_up       (link_up),
        .speed_100     (speed_100),
        .full_duplex   (full_duplex),
        .pause_en      (pause_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pat_sel(input int addr, input int round);
        return (addr + 3 * round) % 6;
    endfunction

    function automatic logic [15:0] phy_reg(input int addr, input int regn, input int round);
        int s;
        s = pat_sel(addr, round);
        if (regn == 1) return (s != 0) ? 16'h786D : 16'h7869;
        if (regn == 5) begin
            case (s)
                0: return 16'h05E1;
                1: return 16'h0181;
                2: return 16'h00A1;
                3: return 16'h0441;
                4: return 16'h0021;
                default: return 16'h0501;
            endcase
        end
        return 16'hFFFF;
    endfunction

    // R11 resolution rules applied to the model's register contents
    function automatic logic [3:0] exp_stat(input int addr, input int round, input bit fc);
        logic [15:0] p;
        p = phy_reg(addr, 5, round);
        if (pat_sel(addr, round) == 0) return 4'b0000;
        return {1'b1, p[8] | p[7], p[8] | (!p[7] & p[6]), p[10] & fc};
    endfunction

    function automatic int round_of(input int n);
        return (n < 2 * NP) ? 0 : (n - 2 * NP) / (2 * NP);
    endfunction

    task automatic finish_frame();
        int i;
        int m;
        logic [1:0]  eop;
        logic [4:0]  ereg;
        logic [15:0] edat;
        string tag;
        if (pend) begin
            chk("R10 R11", {link_up[pend_port], speed_100[pend_port],
                            full_duplex[pend_port], pause_en[pend_port]}, pend_exp);
            pend = 0;
        end
        chk("R9", init_done, (fidx >= 2 * NP));
        chk("R2", hdr[12], 1);
        if (fidx < 2 * NP) begin
            i    = fidx / 2;
            eop  = 2'b01;
            ereg = (fidx % 2 == 0) ? 5'd4 : 5'd0;
            edat = (fidx % 2 == 0) ? (16'h01E1 | (fc_s ? 16'h0400 : 16'h0000)) : 16'h1200;
            tag  = "R6";
        end else begin
            m    = fidx - 2 * NP;
            i    = (m / 2) % NP;
            eop  = 2'b10;
            ereg = (m % 2 == 0) ? 5'd1 : 5'd5;
            edat = 16'h0000;
            tag  = "R9";
        end
        chk(tag, hdr[11:10], eop);
        chk(tag, hdr[9:5], BASE + i);
        chk(tag, hdr[4:0], ereg);
        if (eop == 2'b01) chk("R7 R8", dat, edat);
        if (eop == 2'b10 && ereg == 5'd5) begin
            pend      = 1;
            pend_port = rev_s ? (NP - 1 - i) : i;
            pend_exp  = exp_stat(BASE + i, round_of(fidx), fc_s);
        end
        fidx++;
    endtask

    task automatic on_rise();
        if (after_frame) begin
            chk("R3", mdio_oe, 0);
            after_frame = 0;
        end
        if (pos < 0) begin
            if (mdio_oe && mdio_o) ones++;
            else if (mdio_oe && !mdio_o && ones >= 32) begin
                chk("R2", ones, 32);
                pos   = 33;
                hdr   = '0;
                dat   = '0;
                is_rd = 1'b0;
            end else ones = 0;
        end else begin
            if (pos <= 45) begin
                chk("R2", mdio_oe, 1);
                hdr = {hdr[11:0], mdio_o};
                if (pos == 35) is_rd = (hdr[1:0] == 2'b10);
            end else if (pos <= 47) begin
                if (is_rd) chk("R4", mdio_oe, 0);
                else chk("R3", {mdio_oe, mdio_o}, {1'b1, (pos == 46)});
            end else begin
                if (is_rd) begin
                    chk("R4", mdio_oe, 0);
                    dat = {dat[14:0], mdio_line};
                end else begin
                    chk("R3", mdio_oe, 1);
                    dat = {dat[14:0], mdio_o};
                end
            end
            if (pos == 63) begin
                finish_frame();
                pos = -1;
                ones = 0;
                after_frame = 1;
            end else pos++;
        end
    endtask

    // PHY model: drives the turnaround zero and read data after MDC falls
    task automatic on_fall();
        if (is_rd && pos == 47) begin
            phy_drv = 1'b1;
            phy_val = 1'b0;
        end else if (is_rd && pos >= 48 && pos <= 63) begin
            if (pos == 48) rd_val = phy_reg(hdr[9:5], hdr[4:0], round_of(fidx));
            phy_drv = 1'b1;
            phy_val = rd_val[63 - pos];
        end else phy_drv = 1'b0;
    endtask

    always @(posedge clk) k <= rst ? 0 : k + 1;

    always @(negedge clk) begin
        if (rst) begin
            if (rst_d) begin
                chk("R12", {mdc, mdio_oe, init_done}, 0);
                chk("R12", {link_up, speed_100, full_duplex, pause_en}, 0);
            end
            pos = -1; ones = 0; fidx = 0; pend = 0; after_frame = 0;
            prev_mdc = 1'b0; phy_drv = 1'b0; is_rd = 1'b0;
            prev_line = {mdio_oe, mdio_o};
        end else begin
            chk("R1", mdc, ((k % 32) >= 16));
            if ({mdio_oe, mdio_o} != prev_line) chk("R5", (prev_mdc && !mdc), 1);
            prev_line = {mdio_oe, mdio_o};
            if (mdc && !prev_mdc) on_rise();
            if (!mdc && prev_mdc) on_fall();
            prev_mdc = mdc;
        end
        rst_d = rst;
    end

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual fidx %0d expected completion", fidx);
        summary();
    end

    initial begin
        // run 1: flow control on, forward order; straps flipped after release (R8)
        rst = 1'b1; fc_pin = 1'b1; rev_pin = 1'b0; fc_s = 1; rev_s = 0;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0; fc_pin = 1'b0; rev_pin = 1'b1;
        wait (fidx == 6 * NP);
        // run 2: flow control off, reversed order (R10)
        @(posedge clk);
        #1;
        rst = 1'b1; fc_pin = 1'b0; rev_pin = 1'b1; fc_s = 0; rev_s = 1;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0; fc_pin = 1'b1; rev_pin = 1'b0;
        wait (fidx == 4 * NP);
        @(posedge clk);
        #1;
        summary();
    end

endmodule